// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

This block counts hardware events for performance analysis. A vector of single-cycle event pulses comes in from the surrounding logic. Each of sixteen 48-bit counters is given an 8-bit code that picks one line of that vector. A counter advances by one in every cycle in which its chosen line is high, but only while both the unit-wide run bit and the counter's own enable bit are set.

Software reaches the unit over a simple register port. The port carries a write strobe, a byte address and a width flag. Registers are 32 bits wide. Counters can be accessed either as one 64-bit word or as two 32-bit halves. When a counter rolls over, it latches a sticky overflow flag. Any flag that is not masked raises a registered interrupt line. Software then clears each flag by writing a 1 to its bit in a clear register.

Top module: `evctr_unit`

## Requirements
- R1: After reset, every counter, counter enable, event code and overflow flag is 0, the run bit is 0, all sixteen mask bits (offset 0x0804) are 1, and `irq_o` is 0.
- R2: Counter n sits at byte offset 0x1F00 + 8*n. A wide access there transfers all 48 bits, with bits 63:48 reading 0 and ignored on write. A narrow access at 8*n transfers bits 31:0. A narrow access at 8*n+4 transfers bits 47:32 in data bits 15:0; the upper data bits read 0 and are ignored on write.
- R3: Counter n takes its event code from the select register at 0x1E80 + 4*(n/4), bits [8*(n%4)+7 : 8*(n%4)]. Each cycle in which the selected event line is high, the counter increments by exactly 1.
- R4: Code 0xFF selects nothing. A code at or above the event-vector width (64 by default) also selects nothing. A counter holding such a code never increments.
- R5: A counter advances only when bit 0 of the run register (0x1E00) and bit n of the enable register (0x1E04) are both 1. The other bits of the run register read 0.
- R6: On an event at value 2^48-1, the counter goes to 0 and overflow flag n (0x0808, bit n) is set on the same clock edge. The flag stays set until it is cleared.
- R7: Writing 1 to bit n of the clear register (0x080C) clears flag n. Writing 0 leaves the flag unchanged. The clear register reads 0. Writes to the flag register itself are ignored.
- R8: When a flag is set by a rollover and cleared by a write on the same edge, it ends up set.
- R9: Mask bit n = 1 blocks flag n from the interrupt. `irq_o` is the OR of all flags whose mask bit is 0, registered, so it follows a flag or mask change by one cycle.
- R10: A software write to a counter on the same edge as an event for that counter wins, and the event is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| ev_i | input | 64 | Event pulse vector |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The embedded properties check several rules on every cycle. A counter moves by at most one step per cycle. A counter holding the none code, or a counter that is not running, holds its value. A wide write lands exactly. A flag that is not cleared never drops. A rollover always leaves its flag set, even against a clear. A fully masked unit keeps the interrupt low. The register layout needs the bench's scenarios to show it: byte positions of event codes, half-word counter access, the read-as-zero bits and the clear register reading 0. The bench scenarios also show the exact rollover value, the one-cycle interrupt lag, and the dropped event in a write collision.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

    localparam int NUM_CNT   = 16;
    localparam int CNT_W     = 48;
    localparam int CODE_W    = 8;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 16;
    localparam int CODES_PER = REG_W / CODE_W;
    localparam int IDX_W     = $clog2(NUM_CNT);

    localparam logic [ADDR_W-1:0] A_MASK = 16'h0804;
    localparam logic [ADDR_W-1:0] A_STAT = 16'h0808;
    localparam logic [ADDR_W-1:0] A_CLR  = 16'h080C;
    localparam logic [ADDR_W-1:0] A_RUN  = 16'h1E00;
    localparam logic [ADDR_W-1:0] A_CEN  = 16'h1E04;
    localparam logic [ADDR_W-1:0] A_SEL0 = 16'h1E80;
    localparam logic [ADDR_W-1:0] A_CNT0 = 16'h1F00;

    localparam logic [CODE_W-1:0] CODE_NONE = '1;

    typedef enum logic [2:0] {
        RS_NONE, RS_MASK, RS_STAT, RS_CLR, RS_RUN, RS_CEN, RS_SEL, RS_CNT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } reg_dec_t;

    function automatic reg_dec_t decode(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        logic [ADDR_W-1:0] off_c;
        logic [ADDR_W-1:0] off_s;
        d     = '{sel: RS_NONE, idx: '0, hi: 1'b0};
        off_c = a - A_CNT0;
        off_s = a - A_SEL0;
        if (a[1:0] == 2'b00) begin
            if (a == A_MASK)      d.sel = RS_MASK;
            else if (a == A_STAT) d.sel = RS_STAT;
            else if (a == A_CLR)  d.sel = RS_CLR;
            else if (a == A_RUN)  d.sel = RS_RUN;
            else if (a == A_CEN)  d.sel = RS_CEN;
            else if (a >= A_SEL0 && int'(off_s) < 4 * (NUM_CNT / CODES_PER)) begin
                d.sel = RS_SEL;
                d.idx = IDX_W'(off_s >> 2);
            end else if (a >= A_CNT0 && int'(off_c) < 8 * NUM_CNT) begin
                d.sel = RS_CNT;
                d.idx = off_c[3 +: IDX_W];
                d.hi  = off_c[2];
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/evctr_counter.sv
module evctr_counter
    import evctr_pkg::*;
#(
    parameter int EV_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EV_W-1:0]   ev_vec,
    input  logic [CODE_W-1:0] code,
    input  logic              run,
    input  logic              wr_wide,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  value,
    output logic              wrap
);
    localparam int EV_IDX_W = (EV_W > 1) ? $clog2(EV_W) : 1;

    logic [CNT_W-1:0] value_q, value_d;
    logic             hit, wr_any;

    assign wr_any = wr_wide | wr_lo | wr_hi;
    assign hit    = (code != CODE_NONE) && (int'(code) < EV_W)
                    && ev_vec[code[EV_IDX_W-1:0]];

    always_comb begin
        value_d = value_q;
        wrap    = 1'b0;
        if (wr_wide)      value_d = wdata;
        else if (wr_lo)   value_d[31:0] = wdata[31:0];
        else if (wr_hi)   value_d[CNT_W-1:32] = wdata[CNT_W-33:0];
        else if (run && hit) begin
            value_d = value_q + 1'b1;
            wrap    = &value_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) value_q <= '0;
        else     value_q <= value_d;
    end

    assign value = value_q;

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_any |=> (value_q == $past(value_q)) || (value_q == CNT_W'($past(value_q) + 1'b1)));
    assert_none_code_R4: assert property (@(posedge clk) disable iff (rst)
        (code == CODE_NONE && !wr_any) |=> $stable(value_q));
    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_any) |=> $stable(value_q));
    assert_sw_wins_R10: assert property (@(posedge clk) disable iff (rst)
        wr_wide |=> value_q == $past(wdata));

endmodule

// File: rtl/evctr_ctrl.sv
module evctr_ctrl
    import evctr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  reg_dec_t                      dec,
    input  logic [REG_W-1:0]              wdata,
    input  logic [NUM_CNT-1:0]            wrap,
    output logic                          run_en,
    output logic [NUM_CNT-1:0]            cnt_en,
    output logic [NUM_CNT-1:0][CODE_W-1:0] codes,
    output logic [NUM_CNT-1:0]            mask,
    output logic [NUM_CNT-1:0]            status,
    output logic                          irq
);
    logic [NUM_CNT-1:0] clr_vec;

    assign clr_vec = (bus_wr && dec.sel == RS_CLR) ? wdata[NUM_CNT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_en <= 1'b0;
            cnt_en <= '0;
            codes  <= '0;
            mask   <= '1;
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= (status & ~clr_vec) | wrap;
            irq    <= |(status & ~mask);
            if (bus_wr) begin
                case (dec.sel)
                    RS_RUN:  run_en <= wdata[0];
                    RS_CEN:  cnt_en <= wdata[NUM_CNT-1:0];
                    RS_MASK: mask   <= wdata[NUM_CNT-1:0];
                    RS_SEL: begin
                        for (int c = 0; c < NUM_CNT; c++) begin
                            if (c / CODES_PER == int'(dec.idx))
                                codes[c] <= wdata[CODE_W*(c % CODES_PER) +: CODE_W];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_reset_mask_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask && status == '0 && !irq));
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~$past(clr_vec) & ~status) == '0));
    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        |wrap |=> ((status & $past(wrap)) == $past(wrap)));
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (&mask) |=> !irq);

endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
    import evctr_pkg::*;
#(
    parameter int EV_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    input  logic [EV_W-1:0]   ev_i,
    output logic              irq_o
);
    reg_dec_t                       dec;
    logic                           run_en;
    logic [NUM_CNT-1:0]             cnt_en, mask, status, wrap;
    logic [NUM_CNT-1:0][CODE_W-1:0] codes;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_val;

    assign dec = decode(bus_addr);

    evctr_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .bus_wr (bus_wr),
        .dec    (dec),
        .wdata  (bus_wdata[REG_W-1:0]),
        .wrap   (wrap),
        .run_en (run_en),
        .cnt_en (cnt_en),
        .codes  (codes),
        .mask   (mask),
        .status (status),
        .irq    (irq_o)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic hit_me;
        assign hit_me = bus_wr && dec.sel == RS_CNT && int'(dec.idx) == i;
        evctr_counter #(.EV_W(EV_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .ev_vec  (ev_i),
            .code    (codes[i]),
            .run     (run_en && cnt_en[i]),
            .wr_wide (hit_me && bus_wide && !dec.hi),
            .wr_lo   (hit_me && !bus_wide && !dec.hi),
            .wr_hi   (hit_me && !bus_wide && dec.hi),
            .wdata   (bus_wdata[CNT_W-1:0]),
            .value   (cnt_val[i]),
            .wrap    (wrap[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (dec.sel)
            RS_MASK: bus_rdata = 64'(mask);
            RS_STAT: bus_rdata = 64'(status);
            RS_RUN:  bus_rdata = 64'(run_en);
            RS_CEN:  bus_rdata = 64'(cnt_en);
            RS_SEL: begin
                for (int j = 0; j < CODES_PER; j++)
                    bus_rdata[CODE_W*j +: CODE_W] = codes[CODES_PER*int'(dec.idx) + j];
            end
            RS_CNT: begin
                if (dec.hi)        bus_rdata = 64'(cnt_val[dec.idx] >> 32);
                else if (bus_wide) bus_rdata = 64'(cnt_val[dec.idx]);
                else               bus_rdata = 64'(cnt_val[dec.idx][31:0]);
            end
            default: bus_rdata = '0;
        endcase
    end

    assert_rdata_top_zero_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[63:48] == 16'h0);

endmodule

// File: tb/evctr_unit_tb.sv
module evctr_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [63:0] ev_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    evctr_unit u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_i(ev_i), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        is_wr;
        logic        wide;
        logic [15:0] addr;
        logic [63:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0804, 64'h0000_FFFF, 8'd1},
        '{1'b1, 1'b0, 16'h0804, 64'h0000_00F0, 8'd9},
        '{1'b0, 1'b0, 16'h0804, 64'h0000_00F0, 8'd9},
        '{1'b1, 1'b0, 16'h1E84, 64'h1122_3344, 8'd3},
        '{1'b0, 1'b0, 16'h1E84, 64'h1122_3344, 8'd3},
        '{1'b1, 1'b1, 16'h1F08, 64'hABCD_0000_1234_5678, 8'd2},
        '{1'b0, 1'b1, 16'h1F08, 64'h0000_0000_1234_5678, 8'd2},
        '{1'b1, 1'b0, 16'h1F0C, 64'hFFFF_0009, 8'd2},
        '{1'b0, 1'b1, 16'h1F08, 64'h0000_0009_1234_5678, 8'd2},
        '{1'b0, 1'b0, 16'h1F0C, 64'h0000_0009, 8'd2},
        '{1'b0, 1'b0, 16'h080C, 64'h0, 8'd7},
        '{1'b1, 1'b0, 16'h0808, 64'h0000_FFFF, 8'd7},
        '{1'b0, 1'b0, 16'h0808, 64'h0, 8'd7},
        '{1'b1, 1'b0, 16'h1E00, 64'hFFFF_FFFF, 8'd5},
        '{1'b0, 1'b0, 16'h1E00, 64'h1, 8'd5},
        '{1'b1, 1'b0, 16'h1E00, 64'h0, 8'd5}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic w);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = w;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic w, output logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a; bus_wide = w;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [63:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ev_i = v;
            @(negedge clk);
            ev_i = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] r;
        do_reset();

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) wr(VECS[i].addr, VECS[i].data, VECS[i].wide);
            else begin
                rd(VECS[i].addr, VECS[i].wide, r);
                check($sformatf("table[%0d] R%0d", i, VECS[i].req), r, VECS[i].data);
            end
        end

        // R1: reset state
        do_reset();
        check("R1 irq", {63'b0, irq_o}, 64'h0);
        rd(16'h0804, 1'b0, r); check("R1 mask", r, 64'hFFFF);
        rd(16'h0808, 1'b0, r); check("R1 status", r, 64'h0);
        rd(16'h1E04, 1'b0, r); check("R1 enables", r, 64'h0);
        rd(16'h1E8C, 1'b0, r); check("R1 codes", r, 64'h0);
        rd(16'h1F08, 1'b1, r); check("R1 counter", r, 64'h0);

        // R3: select layout and counting
        wr(16'h1E80, 64'hFF50_FF03, 1'b0);
        wr(16'h1E84, 64'h0000_0700, 1'b0);
        wr(16'h1E04, 64'h0000_0027, 1'b0);
        wr(16'h1E00, 64'h1, 1'b0);
        pulse(64'h8, 5);
        rd(16'h1F00, 1'b1, r); check("R3 count five", r, 64'd5);

        // R5: counter 4 has code 0 but is disabled
        pulse(64'h81, 3);
        rd(16'h1F28, 1'b1, r); check("R3 counter5 code byte1", r, 64'd3);
        rd(16'h1F20, 1'b1, r); check("R5 disabled counter4", r, 64'd0);
        rd(16'h1F00, 1'b1, r); check("R3 counter0 unaffected", r, 64'd5);

        // R4: none code and out-of-range code
        pulse('1, 4);
        rd(16'h1F08, 1'b1, r); check("R4 code FF", r, 64'd0);
        rd(16'h1F10, 1'b1, r); check("R4 code 0x50", r, 64'd0);
        rd(16'h1F00, 1'b1, r); check("R3 all lines", r, 64'd9);

        // R5: global run off
        wr(16'h1E00, 64'h0, 1'b0);
        pulse('1, 2);
        rd(16'h1F00, 1'b1, r); check("R5 run off", r, 64'd9);
        wr(16'h1E00, 64'h1, 1'b0);

        // R6: rollover
        wr(16'h1F00, 64'h0000_FFFF_FFFF_FFFE, 1'b1);
        pulse(64'h8, 1);
        rd(16'h1F00, 1'b1, r); check("R6 at max", r, 64'h0000_FFFF_FFFF_FFFF);
        rd(16'h0808, 1'b0, r); check("R6 no flag yet", r, 64'h0);
        pulse(64'h8, 1);
        rd(16'h1F00, 1'b1, r); check("R6 wrapped", r, 64'h0);
        rd(16'h0808, 1'b0, r); check("R6 flag set", r, 64'h1);

        // R9: masking and registered interrupt
        check("R9 masked irq", {63'b0, irq_o}, 64'h0);
        wr(16'h0804, 64'hFFFE, 1'b0);
        check("R9 irq lag", {63'b0, irq_o}, 64'h0);
        @(negedge clk);
        check("R9 irq up", {63'b0, irq_o}, 64'h1);

        // R7: clear semantics
        wr(16'h080C, 64'h0, 1'b0);
        rd(16'h0808, 1'b0, r); check("R7 zero write", r, 64'h1);
        wr(16'h080C, 64'h1, 1'b0);
        rd(16'h0808, 1'b0, r); check("R7 cleared", r, 64'h0);
        @(negedge clk);
        check("R9 irq down", {63'b0, irq_o}, 64'h0);

        // R8: set and clear on the same edge
        wr(16'h1F00, 64'h0000_FFFF_FFFF_FFFF, 1'b1);
        pulse(64'h8, 1);
        wr(16'h1F00, 64'h0000_FFFF_FFFF_FFFF, 1'b1);
        @(negedge clk);
        ev_i = 64'h8; bus_wr = 1'b1; bus_addr = 16'h080C; bus_wdata = 64'h1;
        @(negedge clk);
        ev_i = '0; bus_wr = 1'b0;
        rd(16'h0808, 1'b0, r); check("R8 set wins", r, 64'h1);
        rd(16'h1F00, 1'b1, r); check("R8 counter wrapped", r, 64'h0);

        // R10: write beats event
        @(negedge clk);
        ev_i = 64'h8; bus_wr = 1'b1; bus_wide = 1'b1; bus_addr = 16'h1F00; bus_wdata = 64'd100;
        @(negedge clk);
        ev_i = '0; bus_wr = 1'b0; bus_wide = 1'b0;
        rd(16'h1F00, 1'b1, r); check("R10 write wins", r, 64'd100);

        finish_run();
    end
endmodule